// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sample Serial Output Framer

This block is the digital output stage of a two-channel, simultaneously sampled 14-bit converter. An active-low frame select, sampled on the system clock, opens a frame on its high-to-low transition. At that moment both channels' parallel sample words are captured and a one-cycle conversion strobe is issued. Each later falling edge of the serial clock advances the frame by one bit slot. The serial clock is the only timing source for the frame: there is no free-running conversion timer.

Each channel's word occupies 18 slots. Slot 0 is a zero. Slots 1 to 14 carry the sample with the most significant bit first. Slots 15 to 17 are zeros. During slots 0 to 17 each output carries its own channel's word. If the frame stays open, slots 18 to 35 carry the other channel's word in the same layout, so both samples can be collected from either pin alone. After slot 35 the outputs stay at zero. Raising the frame select ends the frame at any point, and both outputs return to an idle, disabled, zero level.

Top module: `adc_dual_serializer`

## Requirements
- R1: One clock after `cs_n` is seen high, and from reset, `sdo_oe`, `sdo_a` and `sdo_b` are all 0.
- R2: A clock edge that sees `cs_n` low after seeing it high on the previous edge starts a frame. It captures `sample_a` and `sample_b`, sets `sdo_oe` to 1, selects slot 0 and pulses `conv_strobe` high for exactly one clock.
- R3: A serial clock falling edge (`sclk` sampled 1 and then 0 on consecutive clocks) during an open frame advances the slot by one. Rising edges, and any `sclk` activity while `cs_n` is high, have no effect on the outputs.
- R4: Within a word, slot 0 is 0, slot k for k = 1..14 carries bit 14-k of the word, and slots 15, 16 and 17 are 0.
- R5: During slots 0 to 17, `sdo_a` carries the captured channel A word and `sdo_b` carries the captured channel B word at the same time.
- R6: During slots 18 to 35 the words are swapped: `sdo_a` carries the channel B word and `sdo_b` carries the channel A word, in the R4 layout offset by 18.
- R7: From slot 36 onward both outputs are 0, and further falling edges keep them at 0.
- R8: Changes on `sample_a` or `sample_b` after the frame start do not alter the bits shifted out in that frame.
- R9: Raising `cs_n` part-way through a frame aborts it. The next frame restarts at slot 0 with the samples present at its own start.
- R10: A serial clock falling edge seen on the same clock as a frame start is ignored, so the frame begins at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select; its fall starts a conversion |
| sclk | input | 1 | Serial clock; its falling edges advance the bit slot |
| sample_a | input | 14 | Channel A parallel sample |
| sample_b | input | 14 | Channel B parallel sample |
| sdo_a | output | 1 | Serial output A |
| sdo_b | output | 1 | Serial output B |
| sdo_oe | output | 1 | Output enable for both serial pins |
| conv_strobe | output | 1 | One-clock pulse at conversion start |

## Verification
The framing is driven with sample pairs chosen to tell specific faults apart. All-zero and all-one pairs expose stuck bits and misplaced guard zeros. Alternating patterns with opposite phase on A and B expose an off-by-one slot offset and swapped channels. A pair that differs only in MSB and LSB shows bit-order reversal and truncation at either end. Every pair is run for 40 falling edges, past the end of the chained word, and the inputs are flipped part-way through each frame. Directed runs cover idle serial clocks, aborts, and a falling edge that coincides with the frame start.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  localparam int unsigned SER_DATA_W = 14;
  localparam int unsigned SER_TRAIL  = 3;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } fr_state_e;

endpackage

// File: rtl/adc_ser_edge.sv
module adc_ser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic sclk_fall
);

  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign sclk_fall = sclk_q & ~sclk;

endmodule

// File: rtl/adc_ser_frame_ctl.sv
module adc_ser_frame_ctl
  import adc_ser_pkg::*;
#(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned POS_MAX = 36,
  parameter int unsigned POS_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  output logic              frame_act,
  output logic [POS_W-1:0]  pos,
  output logic              conv_strobe,
  output logic [DATA_W-1:0] cap_a,
  output logic [DATA_W-1:0] cap_b
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(POS_MAX);

  fr_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= FR_IDLE;
      pos         <= '0;
      conv_strobe <= 1'b0;
      cap_a       <= '0;
      cap_b       <= '0;
    end else begin
      conv_strobe <= 1'b0;
      if (cs_fall) begin
        state_q     <= FR_SHIFT;
        pos         <= '0;
        cap_a       <= smp_a;
        cap_b       <= smp_b;
        conv_strobe <= 1'b1;
      end else if (cs_n) begin
        state_q <= FR_IDLE;
        pos     <= '0;
      end else if (state_q == FR_SHIFT && sclk_fall && pos != POS_LAST) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign frame_act = (state_q == FR_SHIFT);

  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !cs_n && !cs_fall && sclk_fall && pos != POS_LAST)
      |=> (pos == $past(pos) + 1'b1));

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !cs_n && !cs_fall && pos == POS_LAST) |=> (pos == POS_LAST));

  // R2
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> (frame_act && pos == '0));

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  // R8
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> ($stable(cap_a) && $stable(cap_b)));

endmodule

// File: rtl/adc_ser_lane.sv
module adc_ser_lane #(
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned WORD_SLOTS = 18,
  parameter int unsigned POS_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] own_w,
  input  logic [DATA_W-1:0] other_w,
  output logic              sdo
);

  localparam int unsigned FRAME_SLOTS = 2 * WORD_SLOTS;

  // slot q of one word: guard zero, data MSB first, trailing zeros
  function automatic logic word_bit(input logic [DATA_W-1:0] w, input int q);
    logic [DATA_W-1:0] t;
    if (q >= 1 && q <= int'(DATA_W)) begin
      t = w << (q - 1);
      return t[DATA_W-1];
    end
    return 1'b0;
  endfunction

  function automatic logic slot_bit(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b,
                                    input int p);
    if (p < int'(WORD_SLOTS))  return word_bit(a, p);
    if (p < int'(FRAME_SLOTS)) return word_bit(b, p - int'(WORD_SLOTS));
    return 1'b0;
  endfunction

  assign sdo = frame_act ? slot_bit(own_w, other_w, int'(pos)) : 1'b0;

  // R4
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && pos == '0) |-> !sdo);

  // R4
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && pos == POS_W'(WORD_SLOTS - 1)) |-> !sdo);

endmodule

// File: rtl/adc_dual_serializer.sv
module adc_dual_serializer
  import adc_ser_pkg::*;
#(
  parameter int unsigned DATA_W = SER_DATA_W,
  parameter int unsigned TRAIL  = SER_TRAIL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_a,
  input  logic [DATA_W-1:0] sample_b,
  output logic              sdo_a,
  output logic              sdo_b,
  output logic              sdo_oe,
  output logic              conv_strobe
);

  localparam int unsigned WORD_SLOTS = 1 + DATA_W + TRAIL;
  localparam int unsigned POS_MAX    = 2 * WORD_SLOTS;
  localparam int unsigned POS_W      = $clog2(POS_MAX + 1);
  localparam int unsigned LANES      = 2;

  logic              cs_fall_w;
  logic              sclk_fall_w;
  logic              frame_act_w;
  logic [POS_W-1:0]  pos_w;
  logic [DATA_W-1:0] cap_w [LANES];
  logic [LANES-1:0]  sdo_w;

  adc_ser_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .cs_fall   (cs_fall_w),
    .sclk_fall (sclk_fall_w)
  );

  adc_ser_frame_ctl #(
    .DATA_W  (DATA_W),
    .POS_MAX (POS_MAX),
    .POS_W   (POS_W)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .cs_fall     (cs_fall_w),
    .sclk_fall   (sclk_fall_w),
    .smp_a       (sample_a),
    .smp_b       (sample_b),
    .frame_act   (frame_act_w),
    .pos         (pos_w),
    .conv_strobe (conv_strobe),
    .cap_a       (cap_w[0]),
    .cap_b       (cap_w[1])
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_ser_lane #(
      .DATA_W     (DATA_W),
      .WORD_SLOTS (WORD_SLOTS),
      .POS_W      (POS_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_act (frame_act_w),
      .pos       (pos_w),
      .own_w     (cap_w[g]),
      .other_w   (cap_w[LANES-1-g]),
      .sdo       (sdo_w[g])
    );
  end

  assign sdo_a  = sdo_w[0];
  assign sdo_b  = sdo_w[1];
  assign sdo_oe = frame_act_w;

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_oe && !sdo_a && !sdo_b));

  // R10
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall_w && sclk_fall_w) |=> (pos_w == '0));

  // R2
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> conv_strobe);

endmodule

// File: tb/adc_dual_serializer_tb_top.sv
module adc_dual_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 14;
  localparam int NVEC  = 6;
  localparam int EDGES = 40;

  // {sample_a, sample_b}
  localparam logic [2*DW-1:0] VEC [NVEC] = '{
    {14'h0000, 14'h0000},
    {14'h3FFF, 14'h3FFF},
    {14'h2AAA, 14'h1555},
    {14'h1555, 14'h2AAA},
    {14'h2001, 14'h0000},
    {14'h0F0F, 14'h3C3C}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk;
  logic [DW-1:0] sample_a, sample_b;
  logic sdo_a, sdo_b, sdo_oe, conv_strobe;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_dual_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample_a(sample_a), .sample_b(sample_b),
    .sdo_a(sdo_a), .sdo_b(sdo_b), .sdo_oe(sdo_oe), .conv_strobe(conv_strobe)
  );

  // {oe, a, b}
  task automatic chk(input string req, input logic [2:0] exp);
    n_chk++;
    if ({sdo_oe, sdo_a, sdo_b} !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,a,b} actual %b expected %b", req,
               {sdo_oe, sdo_a, sdo_b}, exp);
    end
  endtask

  task automatic chk_strobe(input string req, input logic exp);
    n_chk++;
    if (conv_strobe !== exp) begin
      n_fail++;
      $display("FAIL %s: conv_strobe actual %b expected %b", req, conv_strobe, exp);
    end
  endtask

  task automatic sclk_fall();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
  endtask

  // bench model: the whole 36-slot line as one vector, slot p at bit 35-p
  function automatic logic line_bit(input logic [DW-1:0] first,
                                    input logic [DW-1:0] second, input int p);
    logic [35:0] line;
    line = {1'b0, first, 3'b000, 1'b0, second, 3'b000};
    if (p > 35) return 1'b0;
    return line[35-p];
  endfunction

  function automatic logic [2:0] exp_at(input logic [DW-1:0] a,
                                        input logic [DW-1:0] b, input int p);
    return {1'b1, line_bit(a, b, p), line_bit(b, a, p)};
  endfunction

  task automatic open_frame();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample_a = '0; sample_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 3'b000);
    chk_strobe("R2 reset", 1'b0);

    // R3: serial clock while idle has no effect
    sample_a = 14'h3FFF; sample_b = 14'h3FFF;
    repeat (3) sclk_fall();
    chk("R3 idle sclk", 3'b000);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      a = VEC[v][2*DW-1:DW];
      b = VEC[v][DW-1:0];
      sample_a = a; sample_b = b;
      open_frame();
      chk_strobe("R2 strobe", 1'b1);
      chk("R2 slot0", exp_at(a, b, 0));
      @(negedge clk);
      chk_strobe("R2 one pulse", 1'b0);
      for (int p = 1; p <= EDGES; p++) begin
        sclk_fall();
        if (p == 5) begin
          sample_a = ~a; sample_b = ~b; // R8
        end
        if (p < 18)      chk("R4 R5 R8 word1", exp_at(a, b, p));
        else if (p < 36) chk("R6 R8 word2", exp_at(a, b, p));
        else             chk("R7 tail", 3'b100);
      end
      close_frame();
      chk("R1 after frame", 3'b000);
    end

    // R9: abort then restart with fresh samples
    sample_a = 14'h3FFF; sample_b = 14'h0000;
    open_frame();
    repeat (4) sclk_fall();
    close_frame();
    chk("R9 abort idle", 3'b000);
    a = 14'h2000; b = 14'h1FFF;
    sample_a = a; sample_b = b;
    open_frame();
    chk("R9 restart slot0", exp_at(a, b, 0));
    for (int p = 1; p <= 3; p++) begin
      sclk_fall();
      chk("R9 restart slots", exp_at(a, b, p));
    end
    close_frame();

    // R10: falling edge coincident with start is ignored
    a = 14'h2000; b = 14'h0001;
    sample_a = a; sample_b = b;
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) begin cs_n = 1'b0; sclk = 1'b0; end
    @(negedge clk);
    chk("R10 slot0", exp_at(a, b, 0));
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    chk("R3 rise no effect", exp_at(a, b, 0));
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
    chk("R10 slot1 msb", exp_at(a, b, 1));
    close_frame();
    chk("R1 final idle", 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule